// File: doc/BRIEF.md
# Two-Output Routed Interrupt Aggregator

This block gathers 224 interrupt request lines and steers each of them to one of two parent interrupt outputs, output A or output B. For every source, software picks level or edge sensing, active polarity, the output it feeds, and whether it is let through at all. Edge sources are caught in a pending latch that software clears by writing ones. Level sources report their live qualified level.

Software reaches the block through a plain 32-bit register port with a one-bit bank select. The configuration bank holds four per-source bit arrays. The status bank holds the unmasked pending view, a masked-status view for each output, and one summary word. The summary word has one bit per 32-source word for each output, so a handler needs two reads to reach the top pending source: the summary, then the flagged masked-status word.

Top module: `intc_route_agg`

## Requirements
- R1: After reset all type bits read 1 (edge), all polarity bits 0, all routing bits 1, all enable bits 0, all pending bits 0, the summary reads 0 and both outputs are low.
- R2: Configuration bank (bank select 0): source n is bit n%32 of word n/32. Type words sit at byte offsets 0x00-0x18, polarity at 0x1C-0x34, routing at 0x38-0x50 and enable at 0x54-0x6C. Each word reads back the value last written to it.
- R3: A source with type 1 sets its pending bit on a rising input edge when its polarity is 0, and on a falling edge when its polarity is 1. The bit stays set after the input returns until software clears it. The opposite edge never sets it.
- R4: A source with type 0 shows its live qualified level: high for polarity 0, low for polarity 1. A clear write has no lasting effect on it while that level stays asserted, and the bit drops once the level goes away.
- R5: Status bank (bank select 1), byte offsets 0x00-0x18: reading gives the unmasked pending or level state of each source. Writing a 1 clears an edge pending bit. Writing 0 bits leaves the state unchanged.
- R6: An enable bit of 0 removes the source from both masked-status views, the summary and both outputs. Its unmasked pending bit is still latched and still readable.
- R7: A routing bit of 1 sends an enabled source to output A, whose masked-status words are at status offsets 0x38-0x50. A routing bit of 0 sends it to output B, whose masked-status words are at 0x1C-0x34.
- R8: The summary word at status offset 0x7C has bit i (for i from 0 to 6) set when output B's masked word i is nonzero. Bit 8+i is set when output A's masked word i is nonzero. All other bits read 0.
- R9: Each output is an active-high level that is high exactly when any of its masked-status bits is set. It is low again in the cycle after the write that clears the last such bit.
- R10: Inputs pass through a two-flop synchronizer, so a pending bit sets on the third clock edge after the input changes. A clear write that lands on that same edge leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 224 | Asynchronous interrupt source lines |
| bus_bank_i | input | 1 | Bank select: 0 configuration, 1 status |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 7 | Byte address within the bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current bank and address |
| irq_a_o | output | 1 | Parent output A (routing bit 1) |
| irq_b_o | output | 1 | Parent output B (routing bit 0) |

## Verification
The bench aims at the clear write that lands on the same edge as a new edge. A design that lets the clear win would lose that interrupt for good. It also checks that a clear write leaves an asserted level source set, since a design that latched levels like edges would hide a source that is still active. It drives a falling-polarity edge source with the wrong edge first, which catches polarity applied only to level sources. It checks that a disabled source is latched but not reported and that its report appears once the source is enabled, which catches enables that gate the latch instead of the view. A swapped routing sense or a shifted summary field would show up as the wrong output or the wrong summary bit.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 7;
    localparam int IDX_W  = ADDR_W - 2;

    // word index of the summary register in the status bank
    localparam logic [IDX_W-1:0] SUMMARY_IDX = IDX_W'(31);

    typedef enum logic {
        BANK_CFG  = 1'b0,
        BANK_STAT = 1'b1
    } bank_e;

    // word index of word w of array number arr, arrays packed back to back
    function automatic logic [IDX_W-1:0] arr_idx(input int arr, input int words, input int w);
        return IDX_W'(arr * words + w);
    endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 224
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
    import intc_pkg::*;
#(
    parameter int WORDS = 7,
    localparam int NUM  = WORDS * WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [NUM-1:0]    trig_o,
    output logic [NUM-1:0]    pol_o,
    output logic [NUM-1:0]    route_o,
    output logic [NUM-1:0]    en_o
);
    typedef struct packed {
        logic [NUM-1:0] trig;
        logic [NUM-1:0] pol;
        logic [NUM-1:0] route;
        logic [NUM-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int w = 0; w < WORDS; w++) begin
                if (widx_i == arr_idx(0, WORDS, w)) cfg_d.trig[w*WORD_W +: WORD_W]  = wdata_i;
                if (widx_i == arr_idx(1, WORDS, w)) cfg_d.pol[w*WORD_W +: WORD_W]   = wdata_i;
                if (widx_i == arr_idx(2, WORDS, w)) cfg_d.route[w*WORD_W +: WORD_W] = wdata_i;
                if (widx_i == arr_idx(3, WORDS, w)) cfg_d.en[w*WORD_W +: WORD_W]    = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.trig  <= '1;
            cfg_q.pol   <= '0;
            cfg_q.route <= '1;
            cfg_q.en    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign trig_o  = cfg_q.trig;
    assign pol_o   = cfg_q.pol;
    assign route_o = cfg_q.route;
    assign en_o    = cfg_q.en;
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
    parameter int NUM = 224
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NUM-1:0] lvl_i,
    input  logic [NUM-1:0] trig_i,
    input  logic [NUM-1:0] pol_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] edge_o,
    output logic [NUM-1:0] pend_o,
    output logic [NUM-1:0] stat_o
);
    typedef struct packed {
        logic [NUM-1:0] prev;
        logic [NUM-1:0] pend;
    } det_t;

    det_t det_d, det_q;
    logic [NUM-1:0] act, act_prev, edge_hit;

    always_comb begin
        act      = lvl_i ^ pol_i;
        act_prev = det_q.prev ^ pol_i;
        edge_hit = act & ~act_prev;
        det_d      = det_q;
        det_d.prev = lvl_i;
        // a new edge wins over a clear in the same cycle; level sources hold no latch
        det_d.pend = ((det_q.pend & ~clr_i) | edge_hit) & trig_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) det_q <= '0;
        else         det_q <= det_d;
    end

    assign edge_o = edge_hit & trig_i;
    assign pend_o = det_q.pend;
    assign stat_o = (trig_i & det_q.pend) | (~trig_i & act);
endmodule

// File: rtl/intc_route_agg.sv
module intc_route_agg
    import intc_pkg::*;
#(
    parameter int WORDS = 7,
    localparam int NUM  = WORDS * WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM-1:0]    src_i,
    input  logic              bus_bank_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              irq_a_o,
    output logic              irq_b_o
);
    logic [IDX_W-1:0] widx;
    logic             unused_addr_lsb;
    logic [NUM-1:0]   lvl_sync;
    logic [NUM-1:0]   cfg_trig, cfg_pol, cfg_route, cfg_en;
    logic [NUM-1:0]   clr_vec, edge_vec, pend_vec, stat_vec;
    logic [NUM-1:0]   mask_a, mask_b;
    logic [15:0]      summary;
    logic             cfg_wr;

    assign widx            = bus_addr_i[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr_i[1:0];
    assign cfg_wr          = bus_we_i && (bus_bank_i == BANK_CFG);

    intc_sync #(.W(NUM)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (lvl_sync)
    );

    intc_cfg #(.WORDS(WORDS)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (cfg_wr),
        .widx_i  (widx),
        .wdata_i (bus_wdata_i),
        .trig_o  (cfg_trig),
        .pol_o   (cfg_pol),
        .route_o (cfg_route),
        .en_o    (cfg_en)
    );

    intc_detect #(.NUM(NUM)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl_sync),
        .trig_i (cfg_trig),
        .pol_i  (cfg_pol),
        .clr_i  (clr_vec),
        .edge_o (edge_vec),
        .pend_o (pend_vec),
        .stat_o (stat_vec)
    );

    assign mask_a = stat_vec & cfg_en & cfg_route;
    assign mask_b = stat_vec & cfg_en & ~cfg_route;

    always_comb begin
        summary = '0;
        for (int w = 0; w < WORDS; w++) begin
            summary[w]     = |mask_b[w*WORD_W +: WORD_W];
            summary[8 + w] = |mask_a[w*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        clr_vec     = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (bus_bank_i == BANK_CFG) begin
                if (widx == arr_idx(0, WORDS, w)) bus_rdata_o = cfg_trig[w*WORD_W +: WORD_W];
                if (widx == arr_idx(1, WORDS, w)) bus_rdata_o = cfg_pol[w*WORD_W +: WORD_W];
                if (widx == arr_idx(2, WORDS, w)) bus_rdata_o = cfg_route[w*WORD_W +: WORD_W];
                if (widx == arr_idx(3, WORDS, w)) bus_rdata_o = cfg_en[w*WORD_W +: WORD_W];
            end else begin
                if (widx == arr_idx(0, WORDS, w)) bus_rdata_o = stat_vec[w*WORD_W +: WORD_W];
                if (widx == arr_idx(1, WORDS, w)) bus_rdata_o = mask_b[w*WORD_W +: WORD_W];
                if (widx == arr_idx(2, WORDS, w)) bus_rdata_o = mask_a[w*WORD_W +: WORD_W];
                if (bus_we_i && widx == arr_idx(0, WORDS, w))
                    clr_vec[w*WORD_W +: WORD_W] = bus_wdata_i;
            end
        end
        if (bus_bank_i == BANK_STAT && widx == SUMMARY_IDX)
            bus_rdata_o = {16'b0, summary};
    end

    assign irq_a_o = |mask_a;
    assign irq_b_o = |mask_b;
endmodule

// File: rtl/intc_route_agg_chk.sv
module intc_route_agg_chk #(
    parameter int NUM = 224
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NUM-1:0] pend,
    input logic [NUM-1:0] clr,
    input logic [NUM-1:0] trig,
    input logic [NUM-1:0] edge_hit,
    input logic [NUM-1:0] en,
    input logic [15:0]    summary,
    input logic           irq_a,
    input logic           irq_b
);
    // R3: a latched edge stays set while no clear hits it
    a_r3_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~$past(clr) & $past(trig)) & ~pend) == '0));

    // R3: a pending bit only appears after an edge was seen
    a_r3_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend & ~$past(pend)) & ~$past(edge_hit)) == '0));

    // R6: nothing enabled means both outputs stay low
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (!irq_a && !irq_b));

    // R9: outputs agree with the summary fields
    a_r9_out_a_summary: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a == (summary[14:8] != 7'd0));
    a_r9_out_b_summary: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b == (summary[6:0] != 7'd0));

    // R10: a clear on the edge cycle leaves the bit set
    a_r10_clear_collision: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & edge_hit & trig) != '0) |=> (($past(clr & edge_hit & trig) & ~pend) == '0));
endmodule

bind intc_route_agg intc_route_agg_chk #(.NUM(NUM)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .pend     (pend_vec),
    .clr      (clr_vec),
    .trig     (cfg_trig),
    .edge_hit (edge_vec),
    .en       (cfg_en),
    .summary  (summary),
    .irq_a    (irq_a_o),
    .irq_b    (irq_b_o)
);

// File: tb/intc_route_agg_test.sv
module intc_route_agg_test;
    localparam int NUM = 224;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NUM-1:0] src = '0;
    logic        bank = 1'b0;
    logic        we = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    intc_route_agg uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_bank_i  (bank),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_a_o     (irq_a),
        .irq_b_o     (irq_b)
    );

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_irq ? {30'b0, irq_b, irq_a} : rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic chk_rd(input logic b, input logic [6:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(negedge clk);
        bank = b;
        addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = t;
        q.push_back(it);
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [1:0] e, input string t);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {30'b0, e}; it.tag = t;
        q.push_back(it);
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic wr(input logic b, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bank = b; addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        settle(4);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(0, 7'h00, 32'hFFFF_FFFF, "R1 type reset");
        chk_rd(0, 7'h18, 32'hFFFF_FFFF, "R1 type w6 reset");
        chk_rd(0, 7'h28, 32'h0, "R1 polarity reset");
        chk_rd(0, 7'h4C, 32'hFFFF_FFFF, "R1 routing reset");
        chk_rd(0, 7'h54, 32'h0, "R1 enable reset");
        chk_rd(1, 7'h00, 32'h0, "R1 pending reset");
        chk_rd(1, 7'h7C, 32'h0, "R1 summary reset");
        chk_irq(2'b00, "R1 outputs reset");
        // R2 layout readback
        wr(0, 7'h34, 32'h1234_5678);
        chk_rd(0, 7'h34, 32'h1234_5678, "R2 polarity w6 readback");
        chk_rd(0, 7'h18, 32'hFFFF_FFFF, "R2 type w6 untouched");
        wr(0, 7'h34, 32'h0);
        wr(0, 7'h64, 32'h0000_00A5);
        chk_rd(0, 7'h64, 32'h0000_00A5, "R2 enable w4 readback");
        wr(0, 7'h64, 32'h0);

        // R3 rising edge, routed to A
        wr(0, 7'h54, 32'h20);
        src[5] = 1'b1; settle(4);
        chk_rd(1, 7'h00, 32'h20, "R3 rising edge latched");
        chk_rd(1, 7'h38, 32'h20, "R7 masked A word0");
        chk_rd(1, 7'h1C, 32'h0, "R7 masked B word0 empty");
        chk_rd(1, 7'h7C, 32'h100, "R8 summary A bit8");
        chk_irq(2'b01, "R9 output A high");
        src[5] = 1'b0; settle(4);
        chk_rd(1, 7'h00, 32'h20, "R3 edge held after release");
        wr(1, 7'h00, 32'h0);
        chk_rd(1, 7'h00, 32'h20, "R5 zero write no effect");
        wr(1, 7'h00, 32'h20);
        chk_irq(2'b00, "R9 output A low after clear");
        chk_rd(1, 7'h00, 32'h0, "R5 clear by one");

        // R7 route to B
        wr(0, 7'h3C, 32'hFFFF_FEFF);
        wr(0, 7'h58, 32'h100);
        src[40] = 1'b1; settle(4);
        chk_rd(1, 7'h20, 32'h100, "R7 masked B word1");
        chk_rd(1, 7'h3C, 32'h0, "R7 masked A word1 empty");
        chk_rd(1, 7'h7C, 32'h002, "R8 summary B bit1");
        chk_irq(2'b10, "R7 output B only");
        src[40] = 1'b0; settle(4);
        wr(1, 7'h04, 32'h100);
        chk_irq(2'b00, "R9 output B low after clear");

        // R6 disabled source
        src[70] = 1'b1; settle(4);
        chk_rd(1, 7'h08, 32'h40, "R6 raw pending while disabled");
        chk_rd(1, 7'h40, 32'h0, "R6 masked empty while disabled");
        chk_rd(1, 7'h7C, 32'h0, "R6 summary empty while disabled");
        chk_irq(2'b00, "R6 outputs low while disabled");
        wr(0, 7'h5C, 32'h40);
        chk_rd(1, 7'h40, 32'h40, "R6 masked after enable");
        chk_rd(1, 7'h7C, 32'h400, "R8 summary A bit10");
        chk_irq(2'b01, "R6 output after enable");
        wr(0, 7'h5C, 32'h0);
        chk_irq(2'b00, "R6 output after disable");
        src[70] = 1'b0;
        wr(1, 7'h08, 32'h40);
        chk_rd(1, 7'h08, 32'h0, "R5 clear disabled source");

        // R3 falling polarity
        wr(0, 7'h34, 32'h8000_0000);
        wr(0, 7'h6C, 32'h8000_0000);
        src[223] = 1'b1; settle(4);
        chk_rd(1, 7'h18, 32'h0, "R3 rising ignored with falling polarity");
        src[223] = 1'b0; settle(4);
        chk_rd(1, 7'h18, 32'h8000_0000, "R3 falling edge latched");
        chk_rd(1, 7'h7C, 32'h4000, "R8 summary A bit14");
        wr(1, 7'h18, 32'h8000_0000);
        chk_rd(1, 7'h7C, 32'h0, "R8 summary clear");

        // R4 level sources
        wr(0, 7'h0C, 32'hFFFF_FFCF);
        wr(0, 7'h28, 32'h20);
        wr(0, 7'h60, 32'h30);
        settle(2);
        chk_rd(1, 7'h0C, 32'h20, "R4 active-low level shown");
        src[100] = 1'b1; settle(4);
        chk_rd(1, 7'h0C, 32'h30, "R4 active-high level shown");
        wr(1, 7'h0C, 32'h30);
        chk_rd(1, 7'h0C, 32'h30, "R4 clear no lasting effect");
        chk_rd(1, 7'h44, 32'h30, "R4 level in masked A");
        src[100] = 1'b0; src[101] = 1'b1; settle(4);
        chk_rd(1, 7'h0C, 32'h0, "R4 levels removed");
        chk_irq(2'b00, "R4 outputs low");

        // R10 clear colliding with a new edge
        wr(0, 7'h54, 32'h400);
        src[10] = 1'b1; settle(4);
        chk_rd(1, 7'h00, 32'h400, "R10 first edge latched");
        src[10] = 1'b0; settle(4);
        @(negedge clk);
        src[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bank = 1'b1; addr = 7'h00; wdata = 32'h400; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        chk_rd(1, 7'h00, 32'h400, "R10 edge beats clear");
        chk_irq(2'b01, "R10 output stays high");
        wr(1, 7'h00, 32'h400);
        chk_rd(1, 7'h00, 32'h0, "R5 clear without edge");
        src[10] = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule